// File: doc/BRIEF.md
# Gated-clock parallel-in serial-out register

This block turns a parallel word into a serial bit stream. A level-sensitive, active-low load input copies the word into a chain of storage stages. Once load is released, each rising edge of an effective shift clock moves the word one stage toward the output. The effective shift clock is the OR of two interchangeable inputs, so either input can act as the shift clock while the other acts as an active-low gate.

Everything runs on one system clock. The two shift inputs are treated as ordinary sampled signals, and rising edges of their OR are found synchronously. The register is built from `N_CHAIN` segments of `N_STAGES` stages each. The last stage of each segment feeds the serial input of the next segment, so one instance can stand in for several cascaded registers. The block drives the final stage on one output and its complement on a second output.

Top module: `piso_chain`

## Requirements
- R1: While loadN is low at a system clock edge, every stage takes its parIn bit; parIn bit k goes to stage k of the chain, and bit TOTAL-1 (TOTAL = N_STAGES*N_CHAIN) goes to the last stage.
- R2: While loadN is low, lastOut equals parIn[TOTAL-1] combinationally, with no clock edge needed, and lastOutN equals its inverse.
- R3: With loadN high, a shift moves each stage k to stage k+1 and puts serIn into stage 0, so the loaded word appears on lastOut MSB first.
- R4: With shiftEnN low, a low-to-high change of shiftClk causes exactly one shift.
- R5: With shiftClk low, a low-to-high change of shiftEnN causes exactly one shift.
- R6: While either shiftClk or shiftEnN stays high, toggling the other input causes no shift.
- R7: When load is released while both shift inputs are low, no shift happens; only a later rising edge of their OR shifts.
- R8: A rising edge of the OR seen in a cycle where loadN is low is ignored, and it does not cause a shift after load is released.
- R9: A synchronous active-high reset clears every stage and the edge history to zero.
- R10: The segments form one chain. After a load, N_STAGES*N_CHAIN shifts present the whole word MSB first, and the serIn bits follow it.
- R11: lastOutN is always the inverse of lastOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| loadN | input | 1 | Active-low level-sensitive parallel load |
| shiftClk | input | 1 | Shift clock input, ORed with shiftEnN |
| shiftEnN | input | 1 | Active-low shift enable, ORed with shiftClk |
| serIn | input | 1 | Serial bit entering stage 0 |
| parIn | input | N_STAGES*N_CHAIN | Parallel word, bit k loads stage k |
| lastOut | output | 1 | Last stage, or parIn MSB while loading |
| lastOutN | output | 1 | Complement of lastOut |

## Verification
The bench builds the block with N_STAGES = 8 and N_CHAIN = 2. This gives a 16-bit chain, so every read-out crosses the point where one segment hands its last stage to the next. It reaches the full-word MSB-first read-out, the serial bits that follow it, and edges produced from either shift input. It also covers holds, load release with both shift inputs low and with their OR high, and edges that arrive while load is active.

// File: rtl/piso_pkg.sv
package piso_pkg;
  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic load;   // parallel capture, has priority
    logic shift;  // one place toward the last stage
  } pisoStrobes_t;
endpackage

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         loadN,
  input  logic         shiftClk,
  input  logic         shiftEnN,
  output pisoStrobes_t strb
);
  logic orNow;
  logic orPrev;

  // The two shift inputs are symmetric: either one can gate the other.
  assign orNow = shiftClk | shiftEnN;

  // History is kept even while loading, so a release with the OR already
  // high does not look like a fresh edge.
  always_ff @(posedge clk) begin
    if (rst) orPrev <= 1'b0;
    else     orPrev <= orNow;
  end

  always_comb begin
    strb.load  = ~loadN;
    strb.shift = loadN & orNow & ~orPrev;
  end
endmodule

// File: rtl/piso_segment.sv
module piso_segment #(
  parameter int N_STAGES = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                shift,
  input  logic                serIn,
  input  logic [N_STAGES-1:0] parIn,
  output logic                lastBit
);
  logic [N_STAGES-1:0] stageQ;

  always_ff @(posedge clk) begin
    if (rst)        stageQ <= '0;
    else if (load)  stageQ <= parIn;
    else if (shift) stageQ <= {stageQ[N_STAGES-2:0], serIn};
  end

  assign lastBit = stageQ[N_STAGES-1];
endmodule

// File: rtl/piso_datapath.sv
module piso_datapath
  import piso_pkg::*;
#(
  parameter int N_STAGES = 8,
  parameter int N_CHAIN  = 1,
  localparam int TOTAL   = N_STAGES * N_CHAIN
) (
  input  logic             clk,
  input  logic             rst,
  input  pisoStrobes_t     strb,
  input  logic             serIn,
  input  logic [TOTAL-1:0] parIn,
  output logic             lastOut,
  output logic             lastOutN
);
  // link[k] is the serial input of segment k; link[N_CHAIN] is the chain end.
  logic [N_CHAIN:0] link;

  assign link[0] = serIn;

  for (genvar k = 0; k < N_CHAIN; k++) begin : g_seg
    piso_segment #(.N_STAGES(N_STAGES)) u_seg (
      .clk    (clk),
      .rst    (rst),
      .load   (strb.load),
      .shift  (strb.shift),
      .serIn  (link[k]),
      .parIn  (parIn[k*N_STAGES +: N_STAGES]),
      .lastBit(link[k+1])
    );
  end

  // While loading, the top parallel bit flows straight to the output.
  assign lastOut  = strb.load ? parIn[TOTAL-1] : link[N_CHAIN];
  assign lastOutN = ~lastOut;
endmodule

// File: rtl/piso_chain.sv
module piso_chain
  import piso_pkg::*;
#(
  parameter int N_STAGES = 8,
  parameter int N_CHAIN  = 1,
  localparam int TOTAL   = N_STAGES * N_CHAIN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadN,
  input  logic             shiftClk,
  input  logic             shiftEnN,
  input  logic             serIn,
  input  logic [TOTAL-1:0] parIn,
  output logic             lastOut,
  output logic             lastOutN
);
  pisoStrobes_t strb;

  piso_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .loadN   (loadN),
    .shiftClk(shiftClk),
    .shiftEnN(shiftEnN),
    .strb    (strb)
  );

  piso_datapath #(.N_STAGES(N_STAGES), .N_CHAIN(N_CHAIN)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .serIn   (serIn),
    .parIn   (parIn),
    .lastOut (lastOut),
    .lastOutN(lastOutN)
  );
endmodule

// File: rtl/piso_checker.sv
module piso_checker #(
  parameter int N_STAGES = 8,
  parameter int N_CHAIN  = 1,
  localparam int TOTAL   = N_STAGES * N_CHAIN
) (
  input logic             clk,
  input logic             rst,
  input logic             loadN,
  input logic             shiftClk,
  input logic             shiftEnN,
  input logic             serIn,
  input logic [TOTAL-1:0] parIn,
  input logic             lastOut,
  input logic             lastOutN
);
  logic orIn;
  assign orIn = shiftClk | shiftEnN;

  AST_FLOW_THROUGH: assert property (@(posedge clk) disable iff (rst)
    !loadN |-> (lastOut == parIn[TOTAL-1]) && (lastOutN == !parIn[TOTAL-1])); // R2

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (loadN && !$past(loadN) && !$past(rst)) |-> lastOut == $past(parIn[TOTAL-1])); // R1

  AST_NO_EDGE_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (loadN && $past(loadN) && !$past(orIn) && !$past(rst)) |-> $stable(lastOut)); // R7

  AST_HOLD_WHEN_HIGH: assert property (@(posedge clk) disable iff (rst)
    (loadN && $past(loadN) && $past(orIn) && $past(orIn, 2)
     && !$past(rst) && !$past(rst, 2)) |-> $stable(lastOut)); // R6

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && loadN) |-> !lastOut); // R9
endmodule

bind piso_chain piso_checker #(.N_STAGES(N_STAGES), .N_CHAIN(N_CHAIN)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .loadN   (loadN),
  .shiftClk(shiftClk),
  .shiftEnN(shiftEnN),
  .serIn   (serIn),
  .parIn   (parIn),
  .lastOut (lastOut),
  .lastOutN(lastOutN)
);

// File: tb/test_piso_chain.sv
module test_piso_chain;
  localparam int CLK_PERIOD = 10;
  localparam int N_STAGES   = 8;
  localparam int N_CHAIN    = 2;
  localparam int TOTAL      = N_STAGES * N_CHAIN;

  typedef struct {
    logic  val;
    string tag;
  } expItem_t;

  logic             clk = 1'b0;
  logic             rst;
  logic             loadN, shiftClk, shiftEnN, serIn;
  logic [TOTAL-1:0] parIn;
  logic             lastOut, lastOutN;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  expItem_t         expQ[$];
  logic [TOTAL-1:0] model;
  logic             prevOr;

  always #(CLK_PERIOD/2) clk = ~clk;

  piso_chain #(.N_STAGES(N_STAGES), .N_CHAIN(N_CHAIN)) i_piso_chain (
    .clk(clk), .rst(rst), .loadN(loadN), .shiftClk(shiftClk),
    .shiftEnN(shiftEnN), .serIn(serIn), .parIn(parIn),
    .lastOut(lastOut), .lastOutN(lastOutN)
  );

  // Monitor: compare both outputs at the falling edge (R11 on every item).
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      nChecks++;
      if (lastOut !== e.val || lastOutN !== ~e.val) begin
        nFails++;
        $display("FAIL %s (R11 pair): lastOut=%b lastOutN=%b expected %b/%b",
                 e.tag, lastOut, lastOutN, e.val, ~e.val);
      end
    end
  end

  // Driver: apply inputs, let one edge pass, update the reference, queue result.
  task automatic cyc(input logic ld, input logic ck, input logic en,
                     input logic sd, input logic [TOTAL-1:0] pd, input string tag);
    logic orNow;
    expItem_t e;
    loadN = ld; shiftClk = ck; shiftEnN = en; serIn = sd; parIn = pd;
    @(posedge clk);
    orNow = ck | en;
    if (!ld)                model = pd;
    else if (orNow && !prevOr) model = {model[TOTAL-2:0], sd};
    prevOr = orNow;
    #1;
    e.val = ld ? model[TOTAL-1] : pd[TOTAL-1];
    e.tag = tag;
    expQ.push_back(e);
    @(negedge clk); #1;
  endtask

  initial begin
    logic [TOTAL-1:0] curPar;
    rst = 1'b1; loadN = 1'b1; shiftClk = 1'b0; shiftEnN = 1'b0;
    serIn = 1'b0; parIn = '0;
    model = '0; prevOr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    rst = 1'b0;

    cyc(1, 0, 0, 1, '0, "R9");                  // reset state, no shift
    cyc(0, 0, 0, 0, 16'hA5C3, "R2");            // flow-through of MSB = 1
    cyc(0, 0, 0, 0, 16'h3C5A, "R2");            // flow-through of MSB = 0
    curPar = 16'hB26D;
    cyc(0, 0, 0, 0, curPar, "R1");
    cyc(1, 0, 0, 1, curPar, "R7");              // release, both low: no shift
    cyc(1, 0, 0, 1, curPar, "R7");
    for (int i = 0; i < 4; i++) begin           // shiftClk as clock
      cyc(1, 1, 0, i[0], curPar, "R4");
      cyc(1, 0, 0, i[0], curPar, "R3");
    end
    for (int i = 0; i < 4; i++) begin           // shiftEnN as clock
      cyc(1, 0, 1, ~i[0], curPar, "R5");
      cyc(1, 0, 0, ~i[0], curPar, "R5");
    end
    cyc(1, 1, 0, 1, curPar, "R4");
    cyc(1, 1, 1, 0, curPar, "R6");              // shiftClk held high
    cyc(1, 1, 0, 1, curPar, "R6");
    cyc(1, 1, 1, 0, curPar, "R6");
    cyc(1, 0, 1, 1, curPar, "R6");              // shiftEnN held high
    cyc(1, 1, 1, 0, curPar, "R6");
    cyc(1, 0, 1, 1, curPar, "R6");
    cyc(1, 0, 0, 0, curPar, "R6");
    curPar = 16'h9E17;
    cyc(0, 1, 0, 0, curPar, "R8");              // edge during load ignored
    cyc(1, 1, 0, 1, curPar, "R8");              // release with OR high
    cyc(1, 1, 0, 1, curPar, "R8");
    cyc(1, 0, 0, 1, curPar, "R8");
    curPar = 16'hC0F5;
    cyc(0, 0, 0, 0, curPar, "R10");
    for (int i = 0; i < TOTAL + 4; i++) begin   // full chain read-out
      cyc(1, 1, 0, i[0] ^ i[1], curPar, "R10");
      cyc(1, 0, 0, i[0] ^ i[1], curPar, "R10");
    end
    rst = 1'b1;
    cyc(1, 0, 0, 0, curPar, "R9x");             // reset pulse
    model = '0; prevOr = 1'b0;
    void'(expQ.pop_back());
    rst = 1'b0;
    cyc(1, 0, 0, 0, curPar, "R9");
    @(negedge clk); #1;
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule